// File: doc/BRIEF.md
# Dual-Pointer Circular Address Generator

This block produces data addresses for a DSP datapath. It contains two independent generators, so that two operand addresses can be issued in the same cycle. Each generator holds four index pointers, four modify registers, and a length and a base register for each pointer. An access request names one pointer and one modify register. The generator then issues the pointer's current value as the address. After that it steps the pointer by the signed modify value.

When the pointer's length is nonzero, the step stays inside a circular buffer that starts at the pointer's base and holds `length` words. A step that leaves that window is brought back by adding or subtracting the length. When the length is zero, the step is plain addition that wraps at the top of the address space.

A single shared write port loads the registers. The port selects the generator, the register kind and the register slot. Writing an index register also moves that pointer's base to the same value. A later base write can then place the buffer start below the pointer.

Top module: `ag_top`

## Requirements
- R1: Each generator has four independent pointers, and a request on generator g for pointer p leaves the other pointers unchanged. After a request, `addrValid[g]` is high in the following cycle, and `addr[g]` then holds the value of pointer p.
- R2: Addressing is post-modify. The issued address is the pointer value before the step, and the pointer then becomes its old value plus the selected modify register, taken as a signed AW-bit two's-complement number.
- R3: When the pointer's length register is zero, the new pointer is (pointer + modify) mod 2^AW, so steps wrap through both ends of the address space.
- R4: When the length L is nonzero, the sum is compared with the window [base, base+L-1]. If the sum is at or above base+L, L is subtracted. If it is below base, L is added. Otherwise the sum is kept. This is exact for |modify| <= L, for both positive and negative steps.
- R5: Writing an index register (`wrKind` = 2'b00) loads both the pointer and its base with `wrData`. The next access to that pointer issues `wrData`.
- R6: `wrKind` 2'b01 writes modify register `wrSel`, 2'b10 writes the length of pointer `wrSel`, and 2'b11 writes the base of pointer `wrSel`. None of these writes changes any pointer value.
- R7: If an index write and an access hit the same pointer of the same generator in the same cycle, the access issues the old pointer value and the pointer takes the written value, not the stepped one.
- R8: The two generators work at the same time and independently. A write affects only the generator named by `wrGen`.
- R9: Reset (active low) clears all registers and `addr`, and drives `addrValid` low.
- R10: In a cycle with no request, `addrValid[g]` is low in the next cycle and `addr[g]` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrGen | input | GW | Generator targeted by the write |
| wrKind | input | 2 | Register kind: 00 index, 01 modify, 10 length, 11 base |
| wrSel | input | SW | Register slot (pointer or modify number) |
| wrData | input | AW | Write data |
| accReq | input | NGEN | Access request, one bit per generator |
| accPtr | input | NGEN x SW | Pointer select per generator |
| accMod | input | NGEN x SW | Modify-register select per generator |
| addr | output | NGEN x AW | Issued address per generator (registered) |
| addrValid | output | NGEN | Address valid, one cycle after the request |

## Verification
The bench sweeps every modify step from -L to +L over several buffer lengths, including a length of one. It starts each sweep part-way into the buffer, so a wrap comparator that is off by one, or that only handles one direction, issues an address one length outside the window. Steps near 0 and 2^14 with length zero catch a design that wraps or saturates when it should just roll over. The simultaneous index-write-plus-access case exposes a design that lets the stepped pointer overwrite the freshly written one, or that issues the new value too early. Distinct values on all four pointers and on both generators reveal a design whose select or generator decode leaks into a neighbouring pointer.

// File: rtl/ag_pkg.sv
package ag_pkg;

  typedef enum logic [1:0] {
    WR_INDEX  = 2'b00,
    WR_MODIFY = 2'b01,
    WR_LENGTH = 2'b10,
    WR_BASE   = 2'b11
  } agWrKind_e;

  typedef struct packed {
    logic wrIndex;
    logic wrModify;
    logic wrLength;
    logic wrBase;
    logic step;
  } agStrobes_t;

endpackage

// File: rtl/ag_ctrl.sv
module ag_ctrl
  import ag_pkg::*;
#(
  parameter int GEN_ID = 0,
  parameter int GW     = 1
) (
  input  logic          wrEn,
  input  logic [GW-1:0] wrGen,
  input  logic [1:0]    wrKind,
  input  logic          accReq,
  output agStrobes_t    strobes
);

  localparam logic [GW-1:0] MY_ID = GW'(GEN_ID);

  logic hit;

  always_comb begin
    hit = wrEn && (wrGen == MY_ID);
    strobes.wrIndex  = hit && (wrKind == WR_INDEX);
    strobes.wrModify = hit && (wrKind == WR_MODIFY);
    strobes.wrLength = hit && (wrKind == WR_LENGTH);
    strobes.wrBase   = hit && (wrKind == WR_BASE);
    strobes.step     = accReq;
  end

endmodule

// File: rtl/ag_datapath.sv
module ag_datapath
  import ag_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  agStrobes_t    strobes,
  input  logic [SW-1:0] wrSel,
  input  logic [AW-1:0] wrData,
  input  logic [SW-1:0] accPtr,
  input  logic [SW-1:0] accMod,
  output logic [AW-1:0] addr,
  output logic          addrValid
);

  localparam int EW = AW + 2;

  logic [AW-1:0] idxQ  [NPTR];
  logic [AW-1:0] modQ  [NPTR];
  logic [AW-1:0] lenQ  [NPTR];
  logic [AW-1:0] baseQ [NPTR];
  logic [AW-1:0] addrQ;
  logic          validQ;

  logic signed [EW-1:0] curX, modX, baseX, lenX, endX, sumX, wrapX;
  logic [AW-1:0]        nextIdx;

  // Post-modify step with optional circular wrap
  always_comb begin
    curX  = signed'({2'b00, idxQ[accPtr]});
    modX  = signed'({{2{modQ[accMod][AW-1]}}, modQ[accMod]});
    baseX = signed'({2'b00, baseQ[accPtr]});
    lenX  = signed'({2'b00, lenQ[accPtr]});
    endX  = baseX + lenX;
    sumX  = curX + modX;
    if (lenQ[accPtr] == '0)  wrapX = sumX;
    else if (sumX >= endX)   wrapX = sumX - lenX;
    else if (sumX < baseX)   wrapX = sumX + lenX;
    else                     wrapX = sumX;
    nextIdx = wrapX[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPTR; i++) begin
        idxQ[i]  <= '0;
        modQ[i]  <= '0;
        lenQ[i]  <= '0;
        baseQ[i] <= '0;
      end
      addrQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.step;
      if (strobes.step) begin
        addrQ          <= idxQ[accPtr];
        idxQ[accPtr]   <= nextIdx;
      end
      // register write placed last so it wins over the step
      if (strobes.wrIndex) begin
        idxQ[wrSel]  <= wrData;
        baseQ[wrSel] <= wrData;
      end
      if (strobes.wrModify) modQ[wrSel]  <= wrData;
      if (strobes.wrLength) lenQ[wrSel]  <= wrData;
      if (strobes.wrBase)   baseQ[wrSel] <= wrData;
    end
  end

  assign addr      = addrQ;
  assign addrValid = validQ;

endmodule

// File: rtl/ag_top.sv
module ag_top
  import ag_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NGEN = 2,
  localparam int SW  = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int GW  = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [GW-1:0]             wrGen,
  input  logic [1:0]                wrKind,
  input  logic [SW-1:0]             wrSel,
  input  logic [AW-1:0]             wrData,
  input  logic [NGEN-1:0]           accReq,
  input  logic [NGEN-1:0][SW-1:0]   accPtr,
  input  logic [NGEN-1:0][SW-1:0]   accMod,
  output logic [NGEN-1:0][AW-1:0]   addr,
  output logic [NGEN-1:0]           addrValid
);

  for (genvar g = 0; g < NGEN; g++) begin : genUnit
    agStrobes_t strobes;

    ag_ctrl #(.GEN_ID(g), .GW(GW)) uCtrl (
      .wrEn    (wrEn),
      .wrGen   (wrGen),
      .wrKind  (wrKind),
      .accReq  (accReq[g]),
      .strobes (strobes)
    );

    ag_datapath #(.AW(AW), .NPTR(NPTR), .SW(SW)) uPath (
      .clk       (clk),
      .rstN      (rstN),
      .strobes   (strobes),
      .wrSel     (wrSel),
      .wrData    (wrData),
      .accPtr    (accPtr[g]),
      .accMod    (accMod[g]),
      .addr      (addr[g]),
      .addrValid (addrValid[g])
    );
  end

endmodule

// File: rtl/ag_checker.sv
module ag_checker #(
  parameter int AW   = 14,
  parameter int NPTR = 4,
  parameter int NGEN = 2,
  localparam int SW  = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int GW  = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [GW-1:0]           wrGen,
  input logic [1:0]              wrKind,
  input logic [SW-1:0]           wrSel,
  input logic [AW-1:0]           wrData,
  input logic [NGEN-1:0]         accReq,
  input logic [NGEN-1:0][SW-1:0] accPtr,
  input logic [NGEN-1:0][SW-1:0] accMod,
  input logic [NGEN-1:0][AW-1:0] addr,
  input logic [NGEN-1:0]         addrValid
);

  for (genvar g = 0; g < NGEN; g++) begin : genChk
    assert_valid_after_req_R1: assert property (@(posedge clk) disable iff (!rstN)
      accReq[g] |=> addrValid[g]);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
      !accReq[g] |=> (!addrValid[g] && $stable(addr[g])));

    // index write at t, access to that pointer at t+1: address at t+2 is the written data
    assert_index_load_R5: assert property (@(posedge clk) disable iff (!rstN)
      (accReq[g] && $past(rstN) && $past(wrEn && wrKind == 2'b00 && wrGen == GW'(g))
       && accPtr[g] == $past(wrSel))
      |=> addr[g] == $past(wrData, 2));

    // index write and access to the same pointer together: the write survives the step
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      (accReq[g] && $past(rstN)
       && $past(wrEn && wrKind == 2'b00 && wrGen == GW'(g) && accReq[g] && accPtr[g] == wrSel)
       && accPtr[g] == $past(accPtr[g]))
      |=> addr[g] == $past(wrData, 2));
  end

endmodule

bind ag_top ag_checker #(.AW(AW), .NPTR(NPTR), .NGEN(NGEN)) uChecker (.*);

// File: tb/tb_ag_top.sv
`timescale 1ns/1ps
module tb_ag_top;

  localparam int AW   = 14;
  localparam int NPTR = 4;
  localparam int NGEN = 2;
  localparam int SW   = 2;
  localparam int GW   = 1;
  localparam int MASK = (1 << AW) - 1;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    wrEn = 1'b0;
  logic [GW-1:0]           wrGen = '0;
  logic [1:0]              wrKind = '0;
  logic [SW-1:0]           wrSel = '0;
  logic [AW-1:0]           wrData = '0;
  logic [NGEN-1:0]         accReq = '0;
  logic [NGEN-1:0][SW-1:0] accPtr = '0;
  logic [NGEN-1:0][SW-1:0] accMod = '0;
  logic [NGEN-1:0][AW-1:0] addr;
  logic [NGEN-1:0]         addrValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int mIdx  [NGEN][NPTR];
  int mMod  [NGEN][NPTR];
  int mLen  [NGEN][NPTR];
  int mBase [NGEN][NPTR];

  ag_top #(.AW(AW), .NPTR(NPTR), .NGEN(NGEN)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int signedMod(int raw);
    return (raw >= (1 << (AW - 1))) ? raw - (1 << AW) : raw;
  endfunction

  function automatic int stepModel(int idx, int m, int b, int l);
    int t;
    if (l == 0) return (idx + m) & MASK;
    t = idx - b + m;
    t = ((t % l) + l) % l;
    return b + t;
  endfunction

  task automatic doWrite(int g, int kind, int sel, int data);
    wrEn = 1'b1; wrGen = GW'(g); wrKind = 2'(kind); wrSel = SW'(sel); wrData = AW'(data);
    @(negedge clk);
    wrEn = 1'b0;
    case (kind)
      0: begin mIdx[g][sel] = data & MASK; mBase[g][sel] = data & MASK; end
      1: mMod[g][sel] = data & MASK;
      2: mLen[g][sel] = data & MASK;
      default: mBase[g][sel] = data & MASK;
    endcase
  endtask

  task automatic doAccess(int g, int p, int ms, string req);
    int exp;
    exp = mIdx[g][p];
    accReq[g] = 1'b1; accPtr[g] = SW'(p); accMod[g] = SW'(ms);
    @(negedge clk);
    accReq[g] = 1'b0;
    chk(req, int'(addr[g]), exp);
    chk(req, int'(addrValid[g]), 1);
    mIdx[g][p] = stepModel(mIdx[g][p], signedMod(mMod[g][ms]), mBase[g][p], mLen[g][p]);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    automatic int lens[5] = '{0, 1, 3, 5, 8};
    for (int g = 0; g < NGEN; g++)
      for (int p = 0; p < NPTR; p++) begin
        mIdx[g][p] = 0; mMod[g][p] = 0; mLen[g][p] = 0; mBase[g][p] = 0;
      end

    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", int'(addrValid), 0);
    chk("R9 addr", int'(addr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 valid after release", int'(addrValid), 0);
    doAccess(0, 0, 0, "R9 cleared pointer");

    // R7: index write and access on the same pointer in one cycle
    doWrite(0, 1, 1, 4);
    wrEn = 1'b1; wrGen = 1'b0; wrKind = 2'b00; wrSel = 2'd3; wrData = AW'(500);
    accReq[0] = 1'b1; accPtr[0] = 2'd3; accMod[0] = 2'd1;
    @(negedge clk);
    wrEn = 1'b0; accReq[0] = 1'b0;
    chk("R7 old value issued", int'(addr[0]), 0);
    mIdx[0][3] = 500; mBase[0][3] = 500;
    doAccess(0, 3, 1, "R7 write beats step");
    doAccess(0, 3, 1, "R7 stepping after write");

    // R1: four independent pointers
    doWrite(0, 1, 3, 1);
    for (int p = 0; p < NPTR; p++) doWrite(0, 0, p, 1000 + 100 * p);
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < NPTR; p++) doAccess(0, p, 3, "R1 independent pointers");

    // R2/R4/R6 sweep over lengths and every legal step
    for (int g = 0; g < NGEN; g++)
      for (int li = 0; li < 5; li++) begin
        int len, lim, base, off;
        len = lens[li];
        lim = (len == 0) ? 6 : len;
        base = 200 + 37 * g;
        for (int m = -lim; m <= lim; m++) begin
          off = len / 2;
          doWrite(g, 2, 1, len);
          doWrite(g, 1, 2, m);
          doWrite(g, 0, 1, base + off);
          doWrite(g, 3, 1, base);
          doAccess(g, 1, 2, "R6 base write leaves pointer");
          for (int k = 0; k < 2 * len + 2; k++)
            doAccess(g, 1, 2, (len == 0) ? "R2 linear post-modify" : "R4 circular wrap");
        end
      end

    // R3: linear wrap through both ends of the address space
    doWrite(0, 2, 2, 0);
    doWrite(0, 1, 2, 5);
    doWrite(0, 0, 2, MASK - 1);
    for (int k = 0; k < 3; k++) doAccess(0, 2, 2, "R3 upward rollover");
    doWrite(0, 1, 2, -5);
    doWrite(0, 0, 2, 2);
    for (int k = 0; k < 3; k++) doAccess(0, 2, 2, "R3 downward rollover");

    // R8: both generators at once, writes kept apart
    doWrite(1, 2, 0, 0);
    doWrite(1, 1, 0, 7);
    doWrite(1, 0, 0, 777);
    doWrite(0, 2, 0, 0);
    doWrite(0, 1, 0, -3);
    doWrite(0, 0, 0, 50);
    for (int k = 0; k < 4; k++) begin
      int e0, e1;
      e0 = mIdx[0][0]; e1 = mIdx[1][0];
      accReq = 2'b11; accPtr = '0; accMod = '0;
      @(negedge clk);
      accReq = '0;
      chk("R8 gen0 address", int'(addr[0]), e0);
      chk("R8 gen1 address", int'(addr[1]), e1);
      chk("R8 both valid", int'(addrValid), 3);
      mIdx[0][0] = stepModel(e0, -3, mBase[0][0], 0);
      mIdx[1][0] = stepModel(e1, 7, mBase[1][0], 0);
    end
    doWrite(1, 0, 0, 9000);
    doAccess(0, 0, 0, "R8 gen0 untouched by gen1 write");

    // R10: idle cycle holds the address and drops valid
    begin
      int last;
      last = int'(addr[0]);
      @(negedge clk);
      chk("R10 valid low when idle", int'(addrValid[0]), 0);
      chk("R10 address held", int'(addr[0]), last);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule